// File: doc/BRIEF.md
# GPIO Pin Controller with State-Driven Outputs

This block drives 32 general-purpose pins split into two 16-pin banks. Bits 31:16 belong to the transmit-side bank and bits 15:0 to the receive-side bank. Software reaches it through a small word-wide write/read port. The port gives access to a data word, a direction word, one source-select word per bank and a four-entry table of pin patterns. The radio's current activity picks one entry of that table.

Each output pin picks its value from one of four sources: the software data word, the table entry for the current activity, debug bus 0 or debug bus 1. Input pins are not driven. Input pins pass through a two-flop synchronizer before they appear in the data word readback.

The activity tracker is a four-state machine whose states are `ACT_IDLE`, `ACT_TX`, `ACT_RX` and `ACT_FDX`. On every clock it loads the state encoded by the sampled pair {rx_active, tx_active}. Every state can therefore move to any state, including itself, in one step: 00 leads to `ACT_IDLE`, 01 to `ACT_TX`, 10 to `ACT_RX` and 11 to `ACT_FDX`.

Top module: `gpio_atr_ctrl`

## Requirements
- R1: After reset every register and table entry reads zero, `pin_oe` and `pin_out` are all zero, and every pin is an input with select code 0.
- R2: A write with `wr_en` high lands on the next rising edge and not before. Offsets: 0 data, 1 direction, 2 transmit-bank select, 3 receive-bank select, 4 to 7 the table entries for activity states 0 to 3. Reading offsets 1 to 7 returns the stored word.
- R3: `pin_oe[i]` equals direction bit i, where 1 means output. Bits 31:16 control the transmit bank and bits 15:0 control the receive bank.
- R4: An output pin with select code 0 drives the matching bit of the data word.
- R5: An output pin with select code 1 drives its bit of the table entry that the current activity state picks: 0 idle, 1 transmit only, 2 receive only, 3 full duplex.
- R6: Select code 2 drives the pin from `dbg0[i]` and code 3 drives it from `dbg1[i]`. Both debug buses reach the pin with no register in between.
- R7: Pin 16+k takes its select from bits 2k+1:2k of the transmit-select word. Pin k takes its select from bits 2k+1:2k of the receive-select word (k = 0..15).
- R8: The activity state is {rx_active, tx_active} as sampled at a rising edge. Table-driven pins change only after that edge.
- R9: An input pin has `pin_out` low whatever its select code. Its data-word readback bit shows `pin_in` after two rising edges, and the old value after one.
- R10: For output pins, the data-word readback returns the value being driven on `pin_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Word offset for write and read |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| tx_active | input | 1 | Radio transmit activity |
| rx_active | input | 1 | Radio receive activity |
| dbg0 | input | 32 | Debug bus 0, one bit per pin |
| dbg1 | input | 32 | Debug bus 1, one bit per pin |
| pin_in | input | 32 | Raw pin levels |
| pin_out | output | 32 | Driven pin values |
| pin_oe | output | 32 | Pin output enables |

## Verification
The bench samples the outputs in the same cycle as a write strobe and again after it. A design that applies writes combinationally, or a cycle late, fails at one of the two samples. It walks all four activity states and checks the table-driven pins just before and just after each sampling edge. This catches an untracked or swapped {rx, tx} index, and a state update that is combinational or one edge late.

Select words are used in uniform and mixed patterns. These expose a field-to-pin mapping that is off by a bank or by a field. Input pins are checked against every source to confirm they stay undriven. A new `pin_in` value is read back one and two edges after it changes, so a synchronizer of the wrong depth or readback through the wrong bank mask shows up.

// File: rtl/gpio_atr_pkg.sv
package gpio_atr_pkg;

    // Per-pin output source codes
    typedef enum logic [1:0] {
        SRC_SW   = 2'd0,
        SRC_ATR  = 2'd1,
        SRC_DBG0 = 2'd2,
        SRC_DBG1 = 2'd3
    } pin_src_e;

    // Radio activity states, encoded {rx, tx}
    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_TX   = 2'd1,
        ACT_RX   = 2'd2,
        ACT_FDX  = 2'd3
    } act_state_e;

    localparam int unsigned ACT_COUNT = 4;

    // Word offsets on the register port
    localparam int unsigned OFS_DATA  = 0;
    localparam int unsigned OFS_DIR   = 1;
    localparam int unsigned OFS_TXSEL = 2;
    localparam int unsigned OFS_RXSEL = 3;
    localparam int unsigned OFS_ATR0  = 4;

endpackage

// File: rtl/gpio_atr_fsm.sv
module gpio_atr_fsm
    import gpio_atr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_active,
    input  logic       rx_active,
    output logic [1:0] tbl_idx
);

    act_state_e state_q;
    act_state_e state_d;

    // Next state comes only from the sampled activity pair
    always_comb begin
        unique case ({rx_active, tx_active})
            2'b00:   state_d = ACT_IDLE;
            2'b01:   state_d = ACT_TX;
            2'b10:   state_d = ACT_RX;
            default: state_d = ACT_FDX;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACT_IDLE;
        else        state_q <= state_d;
    end

    // Output decode: table entry selected by each state
    always_comb begin
        unique case (state_q)
            ACT_IDLE: tbl_idx = 2'd0;
            ACT_TX:   tbl_idx = 2'd1;
            ACT_RX:   tbl_idx = 2'd2;
            default:  tbl_idx = 2'd3;
        endcase
    end

    // R8: the state follows the pair sampled at the previous edge
    p_state_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (tbl_idx == $past({rx_active, tx_active})));

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_atr_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned ADDR_W = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  wr_addr,
    input  logic [WORD_W-1:0]                  wr_data,
    output logic [WORD_W-1:0]                  data_q,
    output logic [WORD_W-1:0]                  dir_q,
    output logic [WORD_W-1:0]                  txsel_q,
    output logic [WORD_W-1:0]                  rxsel_q,
    output logic [ACT_COUNT-1:0][WORD_W-1:0]   atr_q
);

    logic hit_data, hit_dir, hit_tx, hit_rx;

    assign hit_data = wr_en && (wr_addr == ADDR_W'(OFS_DATA));
    assign hit_dir  = wr_en && (wr_addr == ADDR_W'(OFS_DIR));
    assign hit_tx   = wr_en && (wr_addr == ADDR_W'(OFS_TXSEL));
    assign hit_rx   = wr_en && (wr_addr == ADDR_W'(OFS_RXSEL));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            dir_q   <= '0;
            txsel_q <= '0;
            rxsel_q <= '0;
        end else begin
            if (hit_data) data_q  <= wr_data;
            if (hit_dir)  dir_q   <= wr_data;
            if (hit_tx)   txsel_q <= wr_data;
            if (hit_rx)   rxsel_q <= wr_data;
        end
    end

    // One storage word per activity state
    for (genvar e = 0; e < ACT_COUNT; e++) begin : g_entry
        logic hit_e;
        assign hit_e = wr_en && (wr_addr == ADDR_W'(OFS_ATR0 + e));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     atr_q[e] <= '0;
            else if (hit_e) atr_q[e] <= wr_data;
        end
    end

    // R2: a data-word write is visible one edge later
    p_data_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(OFS_DATA)) |=> (data_q == $past(wr_data)));

    // R2: with no strobe the select words hold
    p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(txsel_q) && $stable(rxsel_q)));

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_atr_pkg::*;
#(
    parameter int unsigned BANK_PINS = 16,
    localparam int unsigned NPINS    = 2 * BANK_PINS
) (
    input  logic [NPINS-1:0] dir,
    input  logic [NPINS-1:0] data,
    input  logic [NPINS-1:0] atr_word,
    input  logic [NPINS-1:0] dbg0,
    input  logic [NPINS-1:0] dbg1,
    input  logic [NPINS-1:0] txsel,
    input  logic [NPINS-1:0] rxsel,
    output logic [NPINS-1:0] pin_out
);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        pin_src_e src;
        logic     bit_v;

        if (p >= BANK_PINS) begin : g_tx
            assign src = pin_src_e'(txsel[2*(p-BANK_PINS) +: 2]);
        end else begin : g_rx
            assign src = pin_src_e'(rxsel[2*p +: 2]);
        end

        always_comb begin
            unique case (src)
                SRC_SW:   bit_v = data[p];
                SRC_ATR:  bit_v = atr_word[p];
                SRC_DBG0: bit_v = dbg0[p];
                default:  bit_v = dbg1[p];
            endcase
        end

        // Input pins never drive
        assign pin_out[p] = bit_v & dir[p];
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced
);

    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            synced <= '0;
        end else begin
            meta_q <= raw;
            synced <= meta_q;
        end
    end

endmodule

// File: rtl/gpio_atr_ctrl.sv
module gpio_atr_ctrl
    import gpio_atr_pkg::*;
#(
    parameter int unsigned BANK_PINS = 16,
    parameter int unsigned ADDR_W    = 3,
    localparam int unsigned NPINS    = 2 * BANK_PINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPINS-1:0]  wr_data,
    output logic [NPINS-1:0]  rd_data,
    input  logic              tx_active,
    input  logic              rx_active,
    input  logic [NPINS-1:0]  dbg0,
    input  logic [NPINS-1:0]  dbg1,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe
);

    logic [NPINS-1:0]                data_q, dir_q, txsel_q, rxsel_q;
    logic [ACT_COUNT-1:0][NPINS-1:0] atr_q;
    logic [1:0]                      tbl_idx;
    logic [NPINS-1:0]                pin_sync;

    gpio_regfile #(.WORD_W(NPINS), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (addr),
        .wr_data (wr_data),
        .data_q  (data_q),
        .dir_q   (dir_q),
        .txsel_q (txsel_q),
        .rxsel_q (rxsel_q),
        .atr_q   (atr_q)
    );

    gpio_atr_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_active (tx_active),
        .rx_active (rx_active),
        .tbl_idx   (tbl_idx)
    );

    gpio_pin_mux #(.BANK_PINS(BANK_PINS)) u_mux (
        .dir      (dir_q),
        .data     (data_q),
        .atr_word (atr_q[tbl_idx]),
        .dbg0     (dbg0),
        .dbg1     (dbg1),
        .txsel    (txsel_q),
        .rxsel    (rxsel_q),
        .pin_out  (pin_out)
    );

    gpio_in_sync #(.WIDTH(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (pin_in),
        .synced (pin_sync)
    );

    assign pin_oe = dir_q;

    // Read mux: data word mixes driven and sampled pins
    always_comb begin
        rd_data = '0;
        if (addr == ADDR_W'(OFS_DATA))
            rd_data = (pin_out & dir_q) | (pin_sync & ~dir_q);
        else if (addr == ADDR_W'(OFS_DIR))
            rd_data = dir_q;
        else if (addr == ADDR_W'(OFS_TXSEL))
            rd_data = txsel_q;
        else if (addr == ADDR_W'(OFS_RXSEL))
            rd_data = rxsel_q;
        else begin
            for (int e = 0; e < ACT_COUNT; e++)
                if (addr == ADDR_W'(OFS_ATR0 + e)) rd_data = atr_q[e];
        end
    end

    // R3: a direction write reaches the enables one edge later
    p_oe_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_DIR)) |=> (pin_oe == $past(wr_data)));

    // R9: no pin drives while its enable is low
    p_input_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);

endmodule

// File: tb/gpio_atr_ctrl_tb_top.sv
module gpio_atr_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  addr;
    logic [31:0] wr_data, rd_data;
    logic        tx_active, rx_active;
    logic [31:0] dbg0, dbg1, pin_in, pin_out, pin_oe;

    always #5 clk = ~clk;

    gpio_atr_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .tx_active (tx_active),
        .rx_active (rx_active),
        .dbg0      (dbg0),
        .dbg1      (dbg1),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    // Reference state built from the requirements
    logic [31:0] m_data, m_dir, m_txsel, m_rxsel, m_s1, m_s2;
    logic [31:0] m_atr [4];
    logic [1:0]  m_state;

    typedef struct {
        logic [31:0] out;
        logic [31:0] oe;
        logic [31:0] rd;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 0;

    function automatic logic [31:0] exp_out();
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < 32; i++) begin
            logic [1:0] c;
            c = (i >= 16) ? m_txsel[2*(i-16) +: 2] : m_rxsel[2*i +: 2];
            case (c)
                2'd0: r[i] = m_data[i];
                2'd1: r[i] = m_atr[m_state][i];
                2'd2: r[i] = dbg0[i];
                default: r[i] = dbg1[i];
            endcase
            r[i] = r[i] & m_dir[i];
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_rd();
        case (addr)
            3'd0: return (exp_out() & m_dir) | (m_s2 & ~m_dir);
            3'd1: return m_dir;
            3'd2: return m_txsel;
            3'd3: return m_rxsel;
            default: return m_atr[addr[1:0]];
        endcase
    endfunction

    // Advance one clock and mirror what the edge commits
    task automatic tick();
        @(posedge clk);
        if (rst_n) begin
            m_s2    = m_s1;
            m_s1    = pin_in;
            m_state = {rx_active, tx_active};
            if (wr_en) begin
                case (addr)
                    3'd0: m_data  = wr_data;
                    3'd1: m_dir   = wr_data;
                    3'd2: m_txsel = wr_data;
                    3'd3: m_rxsel = wr_data;
                    default: m_atr[addr[1:0]] = wr_data;
                endcase
            end
        end
        #1;
    endtask

    // Driver: push the expectation for this cycle, then advance
    task automatic check(input string tag);
        item_t it;
        it.out = exp_out();
        it.oe  = m_dir;
        it.rd  = exp_rd();
        it.tag = tag;
        q.push_back(it);
        tick();
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        addr    = a;
        wr_data = d;
        wr_en   = 1'b1;
        tick();
        wr_en   = 1'b0;
    endtask

    // Monitor: compare away from the active edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_vec++;
            if (pin_out !== it.out || pin_oe !== it.oe || rd_data !== it.rd) begin
                n_bad++;
                $display("FAIL %s: got out=%h oe=%h rd=%h, expected out=%h oe=%h rd=%h",
                         it.tag, pin_out, pin_oe, rd_data, it.out, it.oe, it.rd);
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; addr = 3'd0; wr_data = '0;
        tx_active = 1'b0; rx_active = 1'b0;
        dbg0 = '0; dbg1 = '0; pin_in = 32'h1234_5678;
        m_data = '0; m_dir = '0; m_txsel = '0; m_rxsel = '0;
        m_s1 = '0; m_s2 = '0; m_state = 2'd0;
        for (int e = 0; e < 4; e++) m_atr[e] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        check("R1 reset data readback");
        addr = 3'd1; check("R1 reset direction zero");
        addr = 3'd5; check("R1 reset table entry zero");
        addr = 3'd0; check("R9 input readback after two edges");

        // R2: write lands on the edge, not before
        addr = 3'd1; wr_data = 32'hFFFF_FFFF; wr_en = 1'b1;
        check("R2 direction before edge");
        wr_en = 1'b0;
        check("R2 R3 direction after edge");

        // R4 and R10: software source
        wr(3'd0, 32'hA5A5_5A5A);
        addr = 3'd0; check("R4 R10 software pattern");
        wr(3'd0, 32'h0FF0_1234);
        addr = 3'd0; check("R4 second software pattern");

        // R3: bank split of direction
        wr(3'd1, 32'hFFFF_0000);
        addr = 3'd0; check("R3 transmit bank out, receive bank in");
        wr(3'd1, 32'h0000_FFFF);
        addr = 3'd0; check("R3 receive bank out, transmit bank in");

        // R6: debug sources
        dbg0 = 32'h0F0F_3C3C; dbg1 = 32'h9999_6666;
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd2, 32'hAAAA_AAAA);
        wr(3'd3, 32'hFFFF_FFFF);
        addr = 3'd0; check("R6 tx bank dbg0, rx bank dbg1");
        dbg0 = 32'h5A5A_0000; dbg1 = 32'h0000_A5A5;
        check("R6 debug passes without a register");

        // R7: mixed field patterns
        wr(3'd0, 32'hC3C3_C3C3);
        wr(3'd2, 32'hE4E4_E4E4);
        wr(3'd3, 32'h1B1B_1B1B);
        addr = 3'd2; check("R7 R2 tx select readback");
        addr = 3'd0; check("R7 mixed per-field sources");
        wr(3'd2, 32'h0000_00FF);
        wr(3'd3, 32'hFF00_0000);
        addr = 3'd0; check("R7 sources on edge fields only");

        // R5 and R8: activity table
        wr(3'd4, 32'hC001_0001);
        wr(3'd5, 32'h0F0F_F0F0);
        wr(3'd6, 32'h3333_CCCC);
        wr(3'd7, 32'hFFFF_0000);
        wr(3'd2, 32'h5555_5555);
        wr(3'd3, 32'h5555_5555);
        for (int s = 0; s < 4; s++) begin
            addr = 3'(4 + s); check("R2 table entry readback");
        end
        addr = 3'd0;
        check("R5 idle entry");
        for (int s = 1; s < 4; s++) begin
            tx_active = s[0]; rx_active = s[1];
            check("R8 table output before sampling edge");
            check("R5 R8 table output after sampling edge");
        end
        tx_active = 1'b0; rx_active = 1'b0;
        check("R8 full duplex to idle before edge");
        check("R5 back to idle entry");

        // R9: input pins and synchronizer depth
        wr(3'd1, 32'h0000_0000);
        tx_active = 1'b1;
        pin_in = 32'hDEAD_BEEF;
        addr = 3'd0;
        check("R9 input not yet sampled");
        check("R9 input after one edge");
        check("R9 input after two edges");
        wr(3'd2, 32'hAAAA_AAAA);
        wr(3'd3, 32'hFFFF_FFFF);
        dbg0 = '1; dbg1 = '1;
        check("R9 input pins ignore debug selects");
        wr(3'd1, 32'h00FF_FF00);
        check("R10 mixed bank readback");

        done = 1'b1;
        finish_run();
    end

endmodule